// File: doc/BRIEF.md
# AXI4 Burst Memory Self-Test Master

This block is an AXI4 master that tests a memory on its own after reset. It writes a contiguous region with incrementing bursts, streaming them back to back. It then reads the same region back with bursts of the same shape. Every returned word is compared with a pattern computed from its byte address. Any data mismatch, error response or misplaced last-beat marker sets a sticky error output. A done output rises when every read burst has finished.

The write address and write data channels run on their own, so a slow data path does not hold back address issue and the reverse is also true. Two committed-burst counters keep each channel within a set number of bursts of the other. Reads are gated by write responses, so a location is never read before its write burst has been acknowledged. The cache, protection, QoS and lock qualifiers are held at constant values. The region, the burst length, the burst count, the allowed skew and the pattern seed are all parameters.

Top module: `axi_memtest_master`

## Requirements
- R1: Write burst k goes to address BASE_ADDR + k*BURST_LEN*(DATA_W/8), for k = 0 .. NUM_BURSTS-1 in that order, with awlen = BURST_LEN-1, awsize = log2(DATA_W/8) and awburst = 2'b01 (incrementing). Address and attributes hold steady while awvalid waits for awready.
- R2: The write beat to byte address A carries the data A XOR PAT_SEED, with every strobe bit set.
- R3: Each write burst has exactly BURST_LEN beats. wlast is high on the last beat only, and wdata and wlast hold while wvalid waits for wready.
- R4: The two write channels may differ by at most SKEW_MAX committed bursts. If the data channel stalls on its first beat, exactly SKEW_MAX+1 write addresses are accepted and issue then stops. If the address channel stalls, exactly SKEW_MAX+1 data bursts complete and then the data channel stops.
- R5: bready is always high. A write response with bit 1 of bresp set raises error.
- R6: Read burst k uses the same address and attributes as write burst k. arvalid is raised for burst k only after k+1 write responses have been received.
- R7: rready is always high. A returned word that differs from its address pattern (R2) raises error.
- R8: A read beat with bit 1 of rresp set raises error.
- R9: An rlast that does not match the last beat of the expected BURST_LEN-beat burst (early or missing) raises error.
- R10: error is registered and rises the cycle after the offending handshake. done rises the cycle after the final beat of read burst NUM_BURSTS-1. Both stay high until reset, and reset clears both.
- R11: During reset, all valid outputs, error and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| awaddr | output | ADDR_W | write burst address |
| awlen | output | 8 | beats per burst minus one |
| awsize | output | 3 | log2 bytes per beat |
| awburst | output | 2 | burst type, incrementing |
| awcache | output | 4 | constant qualifier |
| awprot | output | 3 | constant qualifier |
| awqos | output | 4 | constant qualifier |
| awlock | output | 1 | constant qualifier |
| awvalid | output | 1 | write address valid |
| awready | input | 1 | write address accepted |
| wdata | output | DATA_W | write beat data |
| wstrb | output | DATA_W/8 | byte strobes, all set |
| wlast | output | 1 | final beat of burst |
| wvalid | output | 1 | write beat valid |
| wready | input | 1 | write beat accepted |
| bresp | input | 2 | write response code |
| bvalid | input | 1 | write response valid |
| bready | output | 1 | write response accept, held high |
| araddr | output | ADDR_W | read burst address |
| arlen | output | 8 | beats per burst minus one |
| arsize | output | 3 | log2 bytes per beat |
| arburst | output | 2 | burst type, incrementing |
| arcache | output | 4 | constant qualifier |
| arprot | output | 3 | constant qualifier |
| arqos | output | 4 | constant qualifier |
| arlock | output | 1 | constant qualifier |
| arvalid | output | 1 | read address valid |
| arready | input | 1 | read address accepted |
| rdata | input | DATA_W | read beat data |
| rresp | input | 2 | read response code |
| rlast | input | 1 | read final beat marker |
| rvalid | input | 1 | read beat valid |
| rready | output | 1 | read beat accept, held high |
| error | output | 1 | sticky test failure |
| done | output | 1 | all read bursts checked |

## Verification
The bench stalls each write channel in turn to reach the skew limit. A design with an off-by-one in the skew counters would accept one burst too many or too few in these phases. It holds back write responses under irregular ready and valid patterns. A design that keyed reads on accepted write data, not on responses, would raise arvalid before a response arrived. Separate runs inject one fault each: a corrupted data word, a read error response, an early rlast and a write error response. Each catches a design that ignores that fault or reports it a cycle late. Each run also checks that error stays high until the next reset clears it.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam logic [1:0] BURST_INCR   = 2'b01;
  localparam int         RESP_ERR_BIT = 1;
  localparam logic [3:0] CACHE_CONST  = 4'b0000;
  localparam logic [2:0] PROT_CONST   = 3'b000;
  localparam logic [3:0] QOS_CONST    = 4'b0000;
endpackage

// File: rtl/mt_addr_issue.sv
module mt_addr_issue #(
  parameter int                ADDR_W      = 32,
  parameter int                CNT_W       = 4,
  parameter int                NUM_BURSTS  = 8,
  parameter int                BURST_BYTES = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  count
);
  logic              valid_q, valid_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  // commit a burst when the slot is free and the throttle allows it
  always_comb begin
    valid_n = valid_q;
    addr_n  = addr_q;
    cnt_n   = cnt_q;
    if (valid_q && ready) begin
      valid_n = 1'b0;
    end else if (!valid_q && allow && (cnt_q < CNT_W'(NUM_BURSTS))) begin
      valid_n = 1'b1;
      addr_n  = BASE_ADDR + ADDR_W'(cnt_q) * ADDR_W'(BURST_BYTES);
      cnt_n   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      valid_q <= valid_n;
      addr_q  <= addr_n;
      cnt_q   <= cnt_n;
    end
  end

  assign valid = valid_q;
  assign addr  = addr_q;
  assign count = cnt_q;
endmodule

// File: rtl/mt_wdata_gen.sv
module mt_wdata_gen #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 4,
  parameter int                BEAT_W     = 2,
  parameter int                BURST_LEN  = 4,
  parameter int                NUM_BURSTS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
  parameter logic [DATA_W-1:0] PAT_SEED   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow,
  input  logic              wready,
  output logic              wvalid,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast,
  output logic [CNT_W-1:0]  count
);
  localparam int                BYTES     = DATA_W / 8;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic              act_q, act_n;
  logic [BEAT_W-1:0] beat_q, beat_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              fire;

  assign fire = act_q && wready;

  always_comb begin
    act_n  = act_q;
    beat_n = beat_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    if (fire) begin
      addr_n = addr_q + ADDR_W'(BYTES);
      if (beat_q == LAST_BEAT) begin
        act_n  = 1'b0;
        beat_n = '0;
      end else begin
        beat_n = beat_q + 1'b1;
      end
    end else if (!act_q && allow && (cnt_q < CNT_W'(NUM_BURSTS))) begin
      act_n = 1'b1;
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      cnt_q  <= '0;
      addr_q <= BASE_ADDR;
    end else begin
      act_q  <= act_n;
      beat_q <= beat_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
    end
  end

  assign wvalid = act_q;
  assign wdata  = DATA_W'(addr_q) ^ PAT_SEED;
  assign wlast  = act_q && (beat_q == LAST_BEAT);
  assign count  = cnt_q;
endmodule

// File: rtl/mt_rcheck.sv
module mt_rcheck #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 4,
  parameter int                BEAT_W     = 2,
  parameter int                BURST_LEN  = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = '0,
  parameter logic [DATA_W-1:0] PAT_SEED   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  input  logic              resp_err,
  input  logic              rlast,
  output logic              bad_beat,
  output logic [CNT_W-1:0]  done_count
);
  localparam int                BYTES     = DATA_W / 8;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] beat_q, beat_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              exp_last;

  assign exp_last = (beat_q == LAST_BEAT);
  assign bad_beat = rvalid && ((rdata != (DATA_W'(addr_q) ^ PAT_SEED))
                               || resp_err || (rlast != exp_last));

  always_comb begin
    beat_n = beat_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    if (rvalid) begin
      addr_n = addr_q + ADDR_W'(BYTES);
      if (exp_last) begin
        beat_n = '0;
        cnt_n  = cnt_q + 1'b1;
      end else begin
        beat_n = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      cnt_q  <= '0;
      addr_q <= BASE_ADDR;
    end else begin
      beat_q <= beat_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
    end
  end

  assign done_count = cnt_q;
endmodule

// File: rtl/axi_memtest_master.sv
module axi_memtest_master #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                BURST_LEN  = 4,
  parameter int                NUM_BURSTS = 8,
  parameter int                SKEW_MAX   = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0000_1000,
  parameter logic [DATA_W-1:0] PAT_SEED   = 32'h5A5A_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic [3:0]          awcache,
  output logic [2:0]          awprot,
  output logic [3:0]          awqos,
  output logic                awlock,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready,
  output logic [ADDR_W-1:0]   araddr,
  output logic [7:0]          arlen,
  output logic [2:0]          arsize,
  output logic [1:0]          arburst,
  output logic [3:0]          arcache,
  output logic [2:0]          arprot,
  output logic [3:0]          arqos,
  output logic                arlock,
  output logic                arvalid,
  input  logic                arready,
  input  logic [DATA_W-1:0]   rdata,
  input  logic [1:0]          rresp,
  input  logic                rlast,
  input  logic                rvalid,
  output logic                rready,
  output logic                error,
  output logic                done
);
  import mt_pkg::*;

  localparam int BYTES       = DATA_W / 8;
  localparam int SIZE_CODE   = $clog2(BYTES);
  localparam int BURST_BYTES = BURST_LEN * BYTES;
  localparam int CNT_W       = $clog2(NUM_BURSTS + 1);
  localparam int BEAT_W      = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic [CNT_W-1:0] aw_cnt, w_cnt, ar_cnt, b_cnt, b_cnt_n, rd_cnt;
  logic             aw_allow, w_allow, ar_allow;
  logic             r_bad, b_bad, err_q, err_n;
  logic             unused_resp_bits;

  // skew throttles between the two write channels
  assign aw_allow = 32'(aw_cnt) < 32'(w_cnt) + 32'(SKEW_MAX);
  assign w_allow  = 32'(w_cnt) < 32'(aw_cnt) + 32'(SKEW_MAX);
  // a read burst only after its write burst is acknowledged
  assign ar_allow = ar_cnt < b_cnt;

  mt_addr_issue #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_BURSTS(NUM_BURSTS),
    .BURST_BYTES(BURST_BYTES), .BASE_ADDR(BASE_ADDR)
  ) u_aw (
    .clk(clk), .rst_n(rst_n), .allow(aw_allow), .ready(awready),
    .valid(awvalid), .addr(awaddr), .count(aw_cnt)
  );

  mt_wdata_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W),
    .BURST_LEN(BURST_LEN), .NUM_BURSTS(NUM_BURSTS),
    .BASE_ADDR(BASE_ADDR), .PAT_SEED(PAT_SEED)
  ) u_w (
    .clk(clk), .rst_n(rst_n), .allow(w_allow), .wready(wready),
    .wvalid(wvalid), .wdata(wdata), .wlast(wlast), .count(w_cnt)
  );

  mt_addr_issue #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_BURSTS(NUM_BURSTS),
    .BURST_BYTES(BURST_BYTES), .BASE_ADDR(BASE_ADDR)
  ) u_ar (
    .clk(clk), .rst_n(rst_n), .allow(ar_allow), .ready(arready),
    .valid(arvalid), .addr(araddr), .count(ar_cnt)
  );

  mt_rcheck #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .BEAT_W(BEAT_W),
    .BURST_LEN(BURST_LEN), .BASE_ADDR(BASE_ADDR), .PAT_SEED(PAT_SEED)
  ) u_r (
    .clk(clk), .rst_n(rst_n), .rvalid(rvalid), .rdata(rdata),
    .resp_err(rresp[RESP_ERR_BIT]), .rlast(rlast),
    .bad_beat(r_bad), .done_count(rd_cnt)
  );

  assign unused_resp_bits = bresp[0] ^ rresp[0];
  assign b_bad = bvalid && bresp[RESP_ERR_BIT];

  always_comb begin
    b_cnt_n = bvalid ? b_cnt + 1'b1 : b_cnt;
    err_n   = err_q || b_bad || r_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_cnt <= '0;
      err_q <= 1'b0;
    end else begin
      b_cnt <= b_cnt_n;
      err_q <= err_n;
    end
  end

  assign awlen   = 8'(BURST_LEN - 1);
  assign awsize  = 3'(SIZE_CODE);
  assign awburst = BURST_INCR;
  assign awcache = CACHE_CONST;
  assign awprot  = PROT_CONST;
  assign awqos   = QOS_CONST;
  assign awlock  = 1'b0;
  assign arlen   = 8'(BURST_LEN - 1);
  assign arsize  = 3'(SIZE_CODE);
  assign arburst = BURST_INCR;
  assign arcache = CACHE_CONST;
  assign arprot  = PROT_CONST;
  assign arqos   = QOS_CONST;
  assign arlock  = 1'b0;
  assign wstrb   = '1;
  assign bready  = 1'b1;
  assign rready  = 1'b1;
  assign error   = err_q;
  assign done    = (rd_cnt == CNT_W'(NUM_BURSTS));
endmodule

// File: rtl/mt_memtest_chk.sv
module mt_memtest_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 4,
  parameter int SKEW_MAX = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic [ADDR_W-1:0] awaddr,
  input logic              wvalid,
  input logic              wready,
  input logic              wlast,
  input logic [DATA_W-1:0] wdata,
  input logic              arvalid,
  input logic              arready,
  input logic [ADDR_W-1:0] araddr,
  input logic              error,
  input logic              done,
  input logic [CNT_W-1:0]  aw_cnt,
  input logic [CNT_W-1:0]  w_cnt,
  input logic [CNT_W-1:0]  ar_cnt,
  input logic [CNT_W-1:0]  b_cnt
);
  a_r1_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));

  a_r3_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));

  a_r4_skew_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(aw_cnt) <= 32'(w_cnt) + 32'(SKEW_MAX)) &&
    (32'(w_cnt) <= 32'(aw_cnt) + 32'(SKEW_MAX)));

  a_r6_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr));

  a_r6_read_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> ar_cnt <= b_cnt);

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

bind axi_memtest_master mt_memtest_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SKEW_MAX(SKEW_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready),
  .awaddr(awaddr), .wvalid(wvalid), .wready(wready), .wlast(wlast),
  .wdata(wdata), .arvalid(arvalid), .arready(arready), .araddr(araddr),
  .error(error), .done(done), .aw_cnt(aw_cnt), .w_cnt(w_cnt),
  .ar_cnt(ar_cnt), .b_cnt(b_cnt)
);

// File: tb/sim_axi_memtest_master.sv
`timescale 1ns/1ps
module sim_axi_memtest_master;
  localparam int          LEN  = 4;
  localparam int          NUM  = 8;
  localparam int          SKEW = 2;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] SEED = 32'h5A5A_0000;
  localparam int M_NONE = 0, M_DATA = 1, M_RRESP = 2, M_RLAST = 3, M_BRESP = 4;

  logic clk = 1'b0, rst_n;
  always #2 clk = ~clk;

  logic [31:0] awaddr, araddr, wdata, rdata;
  logic [7:0]  awlen, arlen;
  logic [2:0]  awsize, arsize, awprot, arprot;
  logic [1:0]  awburst, arburst, bresp, rresp;
  logic [3:0]  awcache, arcache, awqos, arqos, wstrb;
  logic        awlock, arlock, awvalid, awready, wlast, wvalid, wready;
  logic        bvalid, bready, arvalid, arready, rlast, rvalid, rready;
  logic        error, done;

  axi_memtest_master u0 (
    .clk(clk), .rst_n(rst_n), .awaddr(awaddr), .awlen(awlen), .awsize(awsize),
    .awburst(awburst), .awcache(awcache), .awprot(awprot), .awqos(awqos),
    .awlock(awlock), .awvalid(awvalid), .awready(awready), .wdata(wdata),
    .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready), .araddr(araddr),
    .arlen(arlen), .arsize(arsize), .arburst(arburst), .arcache(arcache),
    .arprot(arprot), .arqos(arqos), .arlock(arlock), .arvalid(arvalid),
    .arready(arready), .rdata(rdata), .rresp(rresp), .rlast(rlast),
    .rvalid(rvalid), .rready(rready), .error(error), .done(done)
  );

  int total = 0, bad = 0;
  int aw_n, w_n, wb_n, b_n, ar_n, rb_n, r_beat, gidx, cyc, mode;
  bit stall_aw, stall_w, pat, model_err, model_done, r_active, cur_bad;
  logic [31:0] r_addr;
  logic [31:0] mem [int unsigned];
  logic [31:0] ar_q [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference slave and per-cycle model, decided at the falling edge
  initial begin
    bit n_awr, n_wr, n_arr, n_bv, n_rv, n_rl;
    logic [1:0] n_br, n_rr;
    logic [31:0] n_rd, a;
    awready = 0; wready = 0; arready = 0; bvalid = 0; bresp = 0;
    rvalid = 0; rdata = 0; rresp = 0; rlast = 0;
    forever begin
      @(negedge clk);
      n_awr = 0; n_wr = 0; n_arr = 0; n_bv = 0; n_rv = 0; n_rl = 0;
      n_br = 0; n_rr = 0; n_rd = 0;
      if (rst_n) begin
        chk(error === model_err, "R10 error flag", 64'(error), 64'(model_err));
        chk(done === model_done, "R10 done flag", 64'(done), 64'(model_done));
        chk(bready === 1'b1, "R5 bready high", 64'(bready), 1);
        chk(rready === 1'b1, "R7 rready high", 64'(rready), 1);
        if (arvalid) chk(ar_n < b_n, "R6 read only after response", ar_n, b_n);
        if (awvalid && awready) begin
          chk(awaddr === BASE + 32'(aw_n * LEN * 4), "R1 awaddr", awaddr, BASE + 32'(aw_n * LEN * 4));
          chk(awlen == 8'(LEN - 1) && awsize == 3'd2 && awburst == 2'b01,
              "R1 aw attributes", {awlen, awsize, awburst}, {8'(LEN - 1), 3'd2, 2'b01});
          aw_n++;
        end
        if (wvalid && wready) begin
          a = BASE + 32'(w_n * 4);
          chk(wdata === (a ^ SEED), "R2 write pattern", wdata, a ^ SEED);
          chk(wstrb === 4'hF, "R2 strobes", wstrb, 4'hF);
          chk(wlast === ((w_n % LEN) == LEN - 1), "R3 wlast placement", 64'(wlast), 64'((w_n % LEN) == LEN - 1));
          mem[a] = wdata;
          if ((w_n % LEN) == LEN - 1) wb_n++;
          w_n++;
        end
        if (bvalid && bready) begin
          if (bresp[1]) model_err = 1;
          b_n++;
        end
        if (arvalid && arready) begin
          chk(araddr === BASE + 32'(ar_n * LEN * 4), "R6 araddr", araddr, BASE + 32'(ar_n * LEN * 4));
          chk(arlen == 8'(LEN - 1) && arsize == 3'd2 && arburst == 2'b01,
              "R6 ar attributes", {arlen, arsize, arburst}, {8'(LEN - 1), 3'd2, 2'b01});
          ar_q.push_back(araddr);
          ar_n++;
        end
        if (rvalid && rready) begin
          if (cur_bad) model_err = 1;
          gidx++;
          if (r_beat == LEN - 1) begin
            r_active = 0; rb_n++;
            if (rb_n == NUM) model_done = 1;
          end else r_beat++;
        end
        n_awr = !stall_aw && !(pat && (cyc % 3) == 0);
        n_wr  = !stall_w && !(pat && (cyc % 4) == 1);
        n_arr = !(pat && (cyc % 5) == 2);
        n_bv  = (b_n < ((aw_n < wb_n) ? aw_n : wb_n)) && !(pat && (cyc % 2) == 1);
        n_br  = (mode == M_BRESP && b_n == 2) ? 2'b10 : 2'b00;
        if (!r_active && ar_q.size() > 0) begin
          r_addr = ar_q.pop_front(); r_active = 1; r_beat = 0;
        end
        cur_bad = 0;
        if (r_active && !(pat && (cyc % 3) == 1)) begin
          a = r_addr + 32'(r_beat * 4);
          n_rv = 1;
          n_rd = mem.exists(a) ? mem[a] : 32'h0;
          n_rl = (r_beat == LEN - 1);
          if (gidx == 5 && mode == M_DATA)  begin n_rd = n_rd ^ 32'h1; cur_bad = 1; end
          if (gidx == 5 && mode == M_RRESP) begin n_rr = 2'b10; cur_bad = 1; end
          if (gidx == 5 && mode == M_RLAST) begin n_rl = !n_rl; cur_bad = 1; end
        end
        cyc++;
      end
      @(posedge clk);
      awready <= n_awr; wready <= n_wr; arready <= n_arr;
      bvalid <= n_bv; bresp <= n_br;
      rvalid <= n_rv; rdata <= n_rd; rresp <= n_rr; rlast <= n_rl;
    end
  end

  task automatic run_test(input int m, input bit p, input bit saw, input bit sw);
    rst_n = 0;
    mode = m; pat = p; stall_aw = saw; stall_w = sw;
    aw_n = 0; w_n = 0; wb_n = 0; b_n = 0; ar_n = 0; rb_n = 0; r_beat = 0;
    gidx = 0; cyc = 0; model_err = 0; model_done = 0; r_active = 0; cur_bad = 0;
    mem.delete(); ar_q.delete();
    repeat (3) @(negedge clk);
    // R11: reset state, also shows error from a prior run cleared (R10)
    chk({awvalid, wvalid, arvalid, error, done} === 5'b0, "R11 reset outputs",
        {awvalid, wvalid, arvalid, error, done}, 0);
    #1 rst_n = 1;
    if (sw || saw) begin
      repeat (100) @(negedge clk);
      #1;
      if (sw) begin
        chk(aw_n == SKEW + 1, "R4 address issue under data stall", aw_n, SKEW + 1);
        chk(w_n == 0, "R4 no data beat while stalled", w_n, 0);
      end else begin
        chk(wb_n == SKEW + 1, "R4 data bursts under address stall", wb_n, SKEW + 1);
        chk(aw_n == 0, "R4 no address while stalled", aw_n, 0);
      end
      stall_aw = 0; stall_w = 0;
    end
    for (int i = 0; i < 3000 && !model_done; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    #1;
    chk(model_done, "R10 run reached done (watchdog)", 64'(model_done), 1);
    chk(done === 1'b1, "R10 done held", 64'(done), 1);
    chk(error === (m != M_NONE), "R10 final error", 64'(error), 64'(m != M_NONE));
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    run_test(M_NONE, 0, 0, 0);   // R1 R2 R3 R6 clean run
    run_test(M_NONE, 1, 0, 0);   // irregular ready/valid, R5 R6 timing
    run_test(M_NONE, 0, 0, 1);   // R4 data channel stall
    run_test(M_NONE, 0, 1, 0);   // R4 address channel stall
    run_test(M_DATA, 0, 0, 0);   // R7 corrupted word
    run_test(M_RRESP, 1, 0, 0);  // R8 read error response
    run_test(M_RLAST, 0, 0, 0);  // R9 early/missing rlast
    run_test(M_BRESP, 1, 0, 0);  // R5 write error response
    run_test(M_NONE, 0, 0, 0);   // R10 reset clears error
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule